// File: doc/BRIEF.md
# CCD Electronic Shutter Sequencer

This block decides, field by field and line by line, when the substrate sweep pulse of a CCD sensor must fire so that the sensor integrates charge for a programmed time. An exposure is made of a number of whole fields plus a partial field. The partial field is set by how many lines at the start of a field are swept. The block also produces a level that is high while the sensor is exposing. It gates the readout pulse and holds off register updates while a multi-field exposure is still running.

The surrounding timing generator supplies a field strobe, a line strobe, the pixel position within the line and a strobe marking the readout point of the readout line. Software-side logic presents a configuration word with a write strobe. The sequencer keeps a staging copy of that word and copies it into its working set at a field start, but only once the previous exposure sequence has completed. The exposure level shares an output with a line-identification toggle. The choice between them takes effect at the readout point.

Top module: `ccd_shutter_seq`

## Requirements
- R1: While `rst_n` is low and after its release until the first field strobe, `sub_o`, `rd_o`, `busy_o`, `exp_o` and `id_exp_o` are all 0.
- R2: With the shutter-enable bit 0, no sweep pulse is produced, the readout pulse appears in every field, `busy_o` stays 0, and `exp_o` is 1 once a readout has occurred (exposure spans a full field).
- R3: A sequence covers fields 0 to SVD. In the sweep field, lines 0 to SHD each carry one sweep pulse, so SHD+1 pulses. `sub_o` is high in the cycles after those in which `pix_i` lies in [SUB_START, SUB_END) on such a line. With SVD = 0 the sweep field is the current field.
- R4: Bit 11 of `cfg_shd_i` is ignored. Only bits 10:0 count lines.
- R5: With SVD ≥ 1, `busy_o` is 1 during fields 0 to SVD-1 of the sequence, and a configuration write while `busy_o` is 1 is discarded. A write while `busy_o` is 0 takes effect at the next field strobe that starts a sequence.
- R6: The sweep burst appears only in field number SPL of the sequence. An SPL above SVD acts as SPL = SVD.
- R7: With the shutter enabled, the readout pulse is issued only in field SVD. `exp_o` goes to 1 when the last sweep pulse of the burst ends and returns to 0 at the readout. With SPL = 0, the high span equals SVD·(lines per field) + (readout line − SHD) lines.
- R8: With the readout-suppress bit set, `rd_o` stays 0 and `exp_o` is not cleared by the readout point.
- R9: `id_exp_o` shows a toggle that flips on each line strobe and clears at the readout point while `exp_sel_i` was 0 at the last readout point. It shows `exp_o` otherwise. Changing from toggle to exposure at a readout point forces `exp_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vd_i | input | 1 | Field start strobe, one cycle, coincides with a line strobe |
| hd_i | input | 1 | Line start strobe, one cycle |
| pix_i | input | PIX_W | Pixel position within the current line |
| rd_i | input | 1 | Readout point strobe in the readout line |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_en_i | input | 1 | Shutter enable |
| cfg_htsg_i | input | 1 | Readout suppress |
| cfg_svd_i | input | SVD_W | Whole-field count |
| cfg_shd_i | input | SHD_W | Swept-line count, MSB ignored |
| cfg_spl_i | input | SVD_W | Sweep field select |
| exp_sel_i | input | 1 | 1 selects exposure level on `id_exp_o` |
| sub_o | output | 1 | Sweep pulse request |
| rd_o | output | 1 | Readout pulse |
| busy_o | output | 1 | Register updates locked out |
| exp_o | output | 1 | Exposure level |
| id_exp_o | output | 1 | Line-identification toggle or exposure level |

## Verification
The sweep sequencer is driven with shutter off, a one-field high-speed setting, a three-field low-speed setting with SPL at 0, an SPL inside the range and an SPL beyond SVD. Pulse counts, first and last swept lines and the field holding the burst tell these settings apart. A write issued mid-sequence is shown to be lost by the burst count of the following sequence. A set SHD bit 11 shows that the MSB is ignored. Readout suppression is told apart from the mode switch by the exposure level at field end. The switch field is the only one where `exp_o` drops without a readout pulse.

// File: rtl/ccd_shutter_seq.sv
module ccd_shutter_seq #(
  parameter int PIX_W     = 12,
  parameter int LINE_W    = 11,
  parameter int SVD_W     = 10,
  parameter int SHD_W     = 12,
  parameter int SUB_START = 52,
  parameter int SUB_END   = 124
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vd_i,
  input  logic             hd_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             rd_i,
  input  logic             cfg_we_i,
  input  logic             cfg_en_i,
  input  logic             cfg_htsg_i,
  input  logic [SVD_W-1:0] cfg_svd_i,
  input  logic [SHD_W-1:0] cfg_shd_i,
  input  logic [SVD_W-1:0] cfg_spl_i,
  input  logic             exp_sel_i,
  output logic             sub_o,
  output logic             rd_o,
  output logic             busy_o,
  output logic             exp_o,
  output logic             id_exp_o
);

  localparam int SHD_EFF = SHD_W - 1;
  localparam logic [PIX_W-1:0] WIN_LO = PIX_W'(SUB_START);
  localparam logic [PIX_W-1:0] WIN_HI = PIX_W'(SUB_END);
  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  logic               st_en, st_htsg;
  logic [SVD_W-1:0]   st_svd, st_spl;
  logic [SHD_EFF-1:0] st_shd;
  logic               shd_msb_unused;

  logic               a_en, a_htsg;
  logic [SVD_W-1:0]   a_svd, a_spl;
  logic [LINE_W-1:0]  a_shd;

  logic               started_q;
  logic [LINE_W-1:0]  line_q;
  logic [SVD_W-1:0]   fld_q;
  logic               sub_q, rd_q, exp_q, id_q, mode_q;

  logic in_win, sweep_line, sub_next, final_fld, rd_fire, last_fall, seq_done, switch_now;

  assign shd_msb_unused = cfg_shd_i[SHD_W-1];

  assign busy_o     = started_q && a_en && (fld_q < a_svd);
  assign final_fld  = !a_en || (fld_q == a_svd);
  assign seq_done   = !started_q || !a_en || (fld_q >= a_svd);
  assign in_win     = (pix_i >= WIN_LO) && (pix_i < WIN_HI);
  assign sweep_line = started_q && a_en && (fld_q == a_spl) && (line_q <= a_shd);
  assign sub_next   = sweep_line && in_win;
  assign rd_fire    = rd_i && started_q && final_fld && !a_htsg;
  assign last_fall  = sub_q && !sub_next && (line_q == a_shd);
  assign switch_now = rd_i && exp_sel_i && !mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_en <= 1'b0; st_htsg <= 1'b0; st_svd <= '0; st_spl <= '0; st_shd <= '0;
      a_en <= 1'b0; a_htsg <= 1'b0; a_svd <= '0; a_spl <= '0; a_shd <= '0;
      started_q <= 1'b0;
      line_q <= '0;
      fld_q <= '0;
    end else begin
      if (cfg_we_i && !busy_o) begin
        st_en   <= cfg_en_i;
        st_htsg <= cfg_htsg_i;
        st_svd  <= cfg_svd_i;
        st_spl  <= cfg_spl_i;
        st_shd  <= cfg_shd_i[SHD_EFF-1:0];
      end
      if (vd_i) begin
        line_q <= '0;
        if (seq_done) begin
          a_en      <= st_en;
          a_htsg    <= st_htsg;
          a_svd     <= st_svd;
          a_spl     <= (st_spl > st_svd) ? st_svd : st_spl;
          a_shd     <= LINE_W'(st_shd);
          fld_q     <= '0;
          started_q <= 1'b1;
        end else begin
          fld_q <= fld_q + 1'b1;
        end
      end else if (hd_i && line_q != LINE_MAX) begin
        line_q <= line_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sub_q  <= 1'b0;
      rd_q   <= 1'b0;
      exp_q  <= 1'b0;
      id_q   <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      sub_q <= sub_next;
      rd_q  <= rd_fire;
      if (rd_i) begin
        id_q   <= 1'b0;
        mode_q <= exp_sel_i;
      end else if (hd_i && started_q) begin
        id_q <= ~id_q;
      end
      if (switch_now)
        exp_q <= 1'b0;
      else if (rd_fire)
        exp_q <= !a_en;
      else if (last_fall)
        exp_q <= 1'b1;
    end
  end

  assign sub_o    = sub_q;
  assign rd_o     = rd_q;
  assign exp_o    = exp_q;
  assign id_exp_o = mode_q ? exp_q : id_q;

  AST_SUB_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    sub_o |-> ($past(pix_i) >= WIN_LO && $past(pix_i) < WIN_HI)); // R3
  AST_NO_SUB_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(a_en) |-> !sub_o); // R2
  AST_BUSY_HOLDS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && cfg_we_i) |=> ($stable(st_svd) && $stable(st_shd) && $stable(st_spl) && $stable(st_en))); // R5
  AST_FIELD_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    started_q |-> (fld_q <= a_svd)); // R5
  AST_SPL_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    a_spl <= a_svd); // R6
  AST_READOUT_ENDS_EXP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_o && $past(a_en)) |-> !exp_o); // R7
  AST_HTSG_NO_READOUT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(a_htsg) && $past(started_q)) |-> !rd_o); // R8
  AST_SWITCH_CLEARS_EXP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_q) |-> !exp_o); // R9

endmodule

// File: tb/ccd_shutter_seq_bench.sv
module ccd_shutter_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LPF = 16;
  localparam int LINE_LEN = 140;
  localparam int RD_LINE = 14;
  localparam int RD_PIX = 130;
  localparam int SUB_START = 52;
  localparam int SUB_END = 124;
  localparam int WIN = SUB_END - SUB_START;

  logic clk = 1'b0, rst_n = 1'b0;
  logic vd_i = 0, hd_i = 0, rd_i = 0, cfg_we_i = 0, cfg_en_i = 0, cfg_htsg_i = 0, exp_sel_i = 0;
  logic [11:0] pix_i = '0;
  logic [9:0] cfg_svd_i = '0, cfg_spl_i = '0;
  logic [11:0] cfg_shd_i = '0;
  logic sub_o, rd_o, busy_o, exp_o, id_exp_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccd_shutter_seq u_ccd_shutter_seq (
    .clk(clk), .rst_n(rst_n), .vd_i(vd_i), .hd_i(hd_i), .pix_i(pix_i), .rd_i(rd_i),
    .cfg_we_i(cfg_we_i), .cfg_en_i(cfg_en_i), .cfg_htsg_i(cfg_htsg_i), .cfg_svd_i(cfg_svd_i),
    .cfg_shd_i(cfg_shd_i), .cfg_spl_i(cfg_spl_i), .exp_sel_i(exp_sel_i),
    .sub_o(sub_o), .rd_o(rd_o), .busy_o(busy_o), .exp_o(exp_o), .id_exp_o(id_exp_o));

  int errors = 0, checks = 0;
  int prev_line = 0, prev_pix = LINE_LEN, fcount = 0;
  int f_nsub, f_first, f_last, f_badwin, f_subcyc, f_nrd, f_busy, f_exp_end, f_id_end;
  int rise_f = 0, rise_l = 0, exp_len = -1;
  logic sub_prev = 0, exp_prev = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  task automatic sample();
    if (sub_o) begin
      f_subcyc++;
      if (prev_pix < SUB_START || prev_pix >= SUB_END) f_badwin++;
      if (!sub_prev) begin
        f_nsub++;
        if (f_first < 0) f_first = prev_line;
        f_last = prev_line;
      end
    end
    sub_prev = sub_o;
    if (rd_o) f_nrd++;
    if (prev_line == 1 && prev_pix == 0) f_busy = busy_o;
    if (exp_o && !exp_prev) begin rise_f = fcount; rise_l = prev_line; end
    if (!exp_o && exp_prev) exp_len = (fcount - rise_f) * LPF + prev_line - rise_l;
    exp_prev = exp_o;
  endtask

  task automatic step(input logic vd, input logic hd, input int pix, input logic rd, input int line);
    @(negedge clk);
    sample();
    vd_i = vd; hd_i = hd; pix_i = 12'(pix); rd_i = rd;
    prev_line = line; prev_pix = pix;
  endtask

  task automatic run_field();
    f_nsub = 0; f_first = -1; f_last = -1; f_badwin = 0; f_subcyc = 0; f_nrd = 0; f_busy = -1;
    for (int ln = 0; ln < LPF; ln++)
      for (int px = 0; px < LINE_LEN; px++)
        step(ln == 0 && px == 0, px == 0, px, ln == RD_LINE && px == RD_PIX, ln);
    step(0, 0, LINE_LEN, 0, LPF - 1);
    f_exp_end = exp_o; f_id_end = id_exp_o;
    fcount++;
  endtask

  task automatic cfg(input logic en, input logic htsg, input int svd, input int shd, input int spl);
    cfg_en_i = en; cfg_htsg_i = htsg;
    cfg_svd_i = 10'(svd); cfg_shd_i = 12'(shd); cfg_spl_i = 10'(spl);
    cfg_we_i = 1;
    step(0, 0, LINE_LEN, 0, LPF - 1);
    cfg_we_i = 0;
    step(0, 0, LINE_LEN, 0, LPF - 1);
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    chk({sub_o, rd_o, busy_o, exp_o, id_exp_o} == 5'b0, "R1 outputs in reset", {sub_o, rd_o, busy_o, exp_o, id_exp_o}, 0);
    rst_n = 1;
    repeat (3) step(0, 0, LINE_LEN, 0, LPF - 1);
    chk({sub_o, rd_o, busy_o, exp_o, id_exp_o} == 5'b0, "R1 outputs after release", {sub_o, rd_o, busy_o, exp_o, id_exp_o}, 0);
  endtask

  task automatic t_disabled();
    cfg(0, 0, 3, 2, 0);
    for (int k = 0; k < 2; k++) begin
      run_field();
      chk(f_nsub == 0, "R2 no sweep when disabled", f_nsub, 0);
      chk(f_nrd == 1, "R2 readout each field", f_nrd, 1);
      chk(f_busy == 0, "R2 never busy", f_busy, 0);
      chk(f_exp_end == 1, "R2 exposure high after readout", f_exp_end, 1);
    end
  endtask

  task automatic t_high_speed();
    cfg(1, 0, 0, 5, 0);
    run_field();
    chk(f_nsub == 6, "R3 pulse count SHD+1", f_nsub, 6);
    chk(f_first == 0 && f_last == 5, "R3 swept lines 0..SHD", f_last, 5);
    chk(f_badwin == 0, "R3 pulse inside pixel window", f_badwin, 0);
    chk(f_subcyc == 6 * WIN, "R3 pulse width", f_subcyc, 6 * WIN);
    chk(f_nrd == 1 && f_exp_end == 0, "R7 readout ends exposure", f_exp_end, 0);
    run_field();
    chk(exp_len == RD_LINE - 5, "R7 high-speed exposure lines", exp_len, RD_LINE - 5);
  endtask

  task automatic t_low_speed();
    cfg(1, 0, 2, 3, 0);
    run_field();
    chk(f_busy == 1 && f_nsub == 4, "R5 field0 busy with burst", f_nsub, 4);
    chk(f_nrd == 0, "R7 no readout before final field", f_nrd, 0);
    run_field();
    chk(f_busy == 1 && f_nsub == 0, "R5 field1 busy no burst", f_busy, 1);
    cfg(1, 0, 0, 1, 0);
    run_field();
    chk(f_busy == 0, "R5 final field not busy", f_busy, 0);
    chk(f_nrd == 1, "R7 readout in field SVD", f_nrd, 1);
    chk(exp_len == 2 * LPF + RD_LINE - 3, "R7 low-speed exposure lines", exp_len, 2 * LPF + RD_LINE - 3);
    run_field();
    chk(f_nsub == 4 && f_busy == 1, "R5 write while busy discarded", f_nsub, 4);
    run_field();
    run_field();
  endtask

  task automatic t_spl();
    cfg(1, 0, 2, 1, 1);
    run_field();
    chk(f_nsub == 0, "R6 no burst in field 0", f_nsub, 0);
    run_field();
    chk(f_nsub == 2 && f_last == 1, "R6 burst in field SPL", f_nsub, 2);
    run_field();
    chk(f_nsub == 0 && f_nrd == 1, "R6 no burst in final field", f_nsub, 0);
    cfg(1, 0, 1, 0, 5);
    run_field();
    chk(f_nsub == 0, "R6 SPL above SVD field 0 empty", f_nsub, 0);
    run_field();
    chk(f_nsub == 1, "R6 SPL clamped to SVD", f_nsub, 1);
  endtask

  task automatic t_htsg_and_switch();
    cfg(1, 1, 0, 2, 0);
    run_field();
    chk(f_nsub == 3, "R8 sweep still produced", f_nsub, 3);
    chk(f_nrd == 0, "R8 readout suppressed", f_nrd, 0);
    chk(f_exp_end == 1, "R8 exposure not cleared", f_exp_end, 1);
    chk(f_id_end == 1, "R9 id toggled after clear", f_id_end, 1);
    exp_sel_i = 1;
    run_field();
    chk(f_exp_end == 0, "R9 switch forces exposure low", f_exp_end, 0);
    chk(f_id_end == 0, "R9 shared output shows exposure", f_id_end, 0);
    run_field();
    chk(f_exp_end == 1 && f_id_end == 1, "R9 exposure shown after switch", f_id_end, 1);
  endtask

  task automatic t_shd_msb();
    cfg(1, 0, 0, 12'h803, 0);
    run_field();
    chk(f_nsub == 4 && f_last == 3, "R4 SHD bit 11 ignored", f_nsub, 4);
  endtask

  initial begin
    t_reset();
    t_disabled();
    t_high_speed();
    t_low_speed();
    t_spl();
    t_htsg_and_switch();
    t_shd_msb();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule